// File: doc/BRIEF.md
# Octal DTR mode switch sequencer

This block moves a serial NOR flash between single-lane extended SPI (1-1-1) and octal double-transfer-rate operation (8D-8D-8D), then proves the switch by reading the manufacturer ID back in the new mode. It sits above a flash command engine. For each step it issues one transaction request that carries the opcode, the address byte count, the address, the dummy cycle count, the data byte count, the write payload and the lane protocol. It takes the read bytes and a completion status back from the engine. Serial shifting, pad timing and clock generation are left to the engine.

Switching on takes three transactions. The first writes the array-read dummy count into the volatile dummy register in the current protocol. The second writes the octal-DTR selector into the volatile mode register. The third reads the ID in 8D-8D-8D. Switching off takes two transactions. The first is a single two-byte register write in 8D-8D-8D, which selects single-lane mode and restores the default dummy count in the same burst, because one-byte transfers are not legal in octal DTR. The second reads the ID in 1-1-1.

The states are ST_IDLE, ST_EN_DUMMY, ST_EN_MODE, ST_DIS_MODE, ST_READ_ID and ST_FINISH. The transitions are:
- ST_IDLE to ST_EN_DUMMY when an enable start is accepted.
- ST_IDLE to ST_DIS_MODE when a disable start is accepted.
- ST_EN_DUMMY to ST_EN_MODE, ST_EN_MODE to ST_READ_ID, and ST_DIS_MODE to ST_READ_ID, each on a clean completion.
- Any command state to ST_FINISH on an error completion.
- ST_READ_ID to ST_FINISH on its completion.
- ST_FINISH to ST_IDLE unconditionally.

Top module: `octal_mode_switcher`

## Requirements
- R1: After reset the block is idle: busy, done and req_valid are 0 and octal_mode is 0 (single-lane).
- R2: While idle, start_enable alone or start_disable alone is accepted. Both high in the same cycle are ignored, and any start while busy is ignored.
- R3: busy goes high the cycle after acceptance and stays high through the done cycle. done is a one-cycle pulse with result 0 = ok, 1 = transaction error, 2 = ID mismatch. Code 3 never appears.
- R4: The first enable request is opcode 0x81, ADDR_BYTES address bytes, address 0x01, 0 dummy, 1 write byte of value 20 in req_wdata[7:0], and the protocol of the current mode (req_proto 0 = 1-1-1, 1 = 8D-8D-8D).
- R5: The second enable request is opcode 0x81 to address 0x00 with 1 write byte 0xE7, in the current-mode protocol and with the same address byte count.
- R6: The enable ID read is opcode 0x9F, 0 address bytes, 8 dummy cycles, ID_LEN read bytes, protocol 8D-8D-8D.
- R7: The first disable request is opcode 0x81, ADDR_BYTES address bytes, address 0x00, 0 dummy, 2 write bytes (0xFF in req_wdata[7:0] sent first, then 0x1F in req_wdata[15:8]), protocol 8D-8D-8D.
- R8: The disable ID read is opcode 0x9F, 0 address bytes, 0 dummy, ID_LEN read bytes, protocol 1-1-1.
- R9: The ID check covers only the first ID_LEN bytes received, in arrival order. Byte i is compared with EXP_ID[8i+7:8i]. A difference or fewer than ID_LEN bytes gives result 2, and bytes after the first ID_LEN are ignored. Read bytes arrive before the completion of the read.
- R10: A completion with rsp_err set aborts the sequence. No further request is issued, and done follows in the next cycle with result 1.
- R11: octal_mode takes the new mode (1 after enable, 0 after disable) only in the done cycle of a result-0 sequence. On any failure it keeps its value.
- R12: A request stays valid with unchanged fields until req_ready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_enable | input | 1 | Request switch into octal DTR |
| start_disable | input | 1 | Request switch back to single-lane |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Completion code, valid with done |
| octal_mode | output | 1 | Current flash mode, 1 = octal DTR |
| req_valid | output | 1 | Transaction request valid |
| req_ready | input | 1 | Engine takes the request |
| req_opcode | output | 8 | Command opcode |
| req_addr_bytes | output | 3 | Address byte count |
| req_addr | output | 32 | Address value |
| req_dummy | output | 5 | Dummy cycle count |
| req_data_len | output | 3 | Data byte count |
| req_is_read | output | 1 | 1 = data in, 0 = data out |
| req_wdata | output | 16 | Write payload, first byte in bits 7:0 |
| req_proto | output | 2 | Lane protocol, 0 = 1-1-1, 1 = 8D-8D-8D |
| rsp_valid | input | 1 | Transaction completion |
| rsp_err | input | 1 | Completion carries an error |
| rd_valid | input | 1 | Read byte valid |
| rd_data | input | 8 | Read byte |

## Verification
The bench injects an error on each transaction of both directions. A design that kept issuing requests after a failure would show an extra request or a late done, and one that committed the mode anyway would show a changed octal_mode. It corrupts single ID positions, sends too few bytes and sends trailing extra bytes: a comparator with the wrong length or the wrong byte order would either accept a bad ID or reject a good one. It also enables from octal mode, asserts both starts together and issues starts while busy, which catches register writes sent in a fixed protocol and starts accepted when they should not be.

// File: rtl/octsw_pkg.sv
`timescale 1ns/1ps
package octsw_pkg;
    localparam logic [7:0] OPC_WR_ANY  = 8'h81;
    localparam logic [7:0] OPC_RD_ID   = 8'h9F;
    localparam logic [7:0] REG_DUMMY   = 8'h01;
    localparam logic [7:0] REG_MODE    = 8'h00;
    localparam logic [7:0] VAL_DUMMY20 = 8'd20;
    localparam logic [7:0] VAL_OCT_ON  = 8'hE7;
    localparam logic [7:0] VAL_SINGLE  = 8'hFF;
    localparam logic [7:0] VAL_DUM_DEF = 8'h1F;
    localparam logic [4:0] ID_DUMMY_8D = 5'd8;

    typedef enum logic [1:0] {
        PROTO_1S = 2'd0,
        PROTO_8D = 2'd1
    } proto_e;

    typedef enum logic [1:0] {
        RES_OK       = 2'd0,
        RES_XFER_ERR = 2'd1,
        RES_ID_BAD   = 2'd2
    } result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EN_DUMMY,
        ST_EN_MODE,
        ST_DIS_MODE,
        ST_READ_ID,
        ST_FINISH
    } state_e;

    typedef struct packed {
        logic [7:0]  opcode;
        logic [2:0]  addr_bytes;
        logic [31:0] addr;
        logic [4:0]  dummy;
        logic [2:0]  data_len;
        logic        is_read;
        logic [15:0] wdata;
        proto_e      proto;
    } req_t;
endpackage

// File: rtl/octsw_req_build.sv
`timescale 1ns/1ps
module octsw_req_build
    import octsw_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int ID_LEN     = 3
) (
    input  state_e step,
    input  logic   target_octal,
    input  logic   cur_octal,
    output req_t   req
);
    localparam logic [2:0] AB  = 3'(ADDR_BYTES);
    localparam logic [2:0] IDN = 3'(ID_LEN);

    proto_e cur_proto;
    assign cur_proto = cur_octal ? PROTO_8D : PROTO_1S;

    always_comb begin
        req = '0;
        unique case (step)
            ST_EN_DUMMY: begin
                req.opcode     = OPC_WR_ANY;
                req.addr_bytes = AB;
                req.addr       = {24'd0, REG_DUMMY};
                req.data_len   = 3'd1;
                req.wdata      = {8'd0, VAL_DUMMY20};
                req.proto      = cur_proto;
            end
            ST_EN_MODE: begin
                req.opcode     = OPC_WR_ANY;
                req.addr_bytes = AB;
                req.addr       = {24'd0, REG_MODE};
                req.data_len   = 3'd1;
                req.wdata      = {8'd0, VAL_OCT_ON};
                req.proto      = cur_proto;
            end
            ST_DIS_MODE: begin
                // two bytes: mode selector, then the neighbouring dummy register
                req.opcode     = OPC_WR_ANY;
                req.addr_bytes = AB;
                req.addr       = {24'd0, REG_MODE};
                req.data_len   = 3'd2;
                req.wdata      = {VAL_DUM_DEF, VAL_SINGLE};
                req.proto      = PROTO_8D;
            end
            ST_READ_ID: begin
                req.opcode   = OPC_RD_ID;
                req.dummy    = target_octal ? ID_DUMMY_8D : 5'd0;
                req.data_len = IDN;
                req.is_read  = 1'b1;
                req.proto    = target_octal ? PROTO_8D : PROTO_1S;
            end
            default: req = '0;
        endcase
    end
endmodule

// File: rtl/octsw_id_check.sv
`timescale 1ns/1ps
module octsw_id_check #(
    parameter int          ID_LEN = 3,
    parameter logic [47:0] EXP_ID = 48'h0000_00A7_19C2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    output logic       match
);
    localparam int CNT_W = $clog2(ID_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ID_LEN);

    logic [CNT_W-1:0] cnt_q;
    logic             bad_q;
    logic [7:0]       exp_byte;

    always_comb begin
        exp_byte = 8'd0;
        for (int i = 0; i < ID_LEN; i++) begin
            if (cnt_q == CNT_W'(i)) exp_byte = EXP_ID[8*i +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
            bad_q <= 1'b0;
        end else if (byte_valid && cnt_q != CNT_FULL) begin
            cnt_q <= cnt_q + 1'b1;
            if (byte_data != exp_byte) bad_q <= 1'b1;
        end
    end

    assign match = (cnt_q == CNT_FULL) && !bad_q;

    initial begin
        a_id_len_range_r9: assert (ID_LEN >= 1 && ID_LEN <= 6)
            else $error("ID_LEN out of range");
    end
endmodule

// File: rtl/octal_mode_switcher.sv
`timescale 1ns/1ps
module octal_mode_switcher
    import octsw_pkg::*;
#(
    parameter int          ADDR_BYTES = 3,
    parameter int          ID_LEN     = 3,
    parameter logic [47:0] EXP_ID     = 48'h0000_00A7_19C2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_enable,
    input  logic        start_disable,
    output logic        busy,
    output logic        done,
    output logic [1:0]  result,
    output logic        octal_mode,
    output logic        req_valid,
    input  logic        req_ready,
    output logic [7:0]  req_opcode,
    output logic [2:0]  req_addr_bytes,
    output logic [31:0] req_addr,
    output logic [4:0]  req_dummy,
    output logic [2:0]  req_data_len,
    output logic        req_is_read,
    output logic [15:0] req_wdata,
    output logic [1:0]  req_proto,
    input  logic        rsp_valid,
    input  logic        rsp_err,
    input  logic        rd_valid,
    input  logic [7:0]  rd_data
);
    state_e  state_q, state_d;
    logic    issued_q, issued_d;
    logic    target_q, target_d;
    result_e res_q, res_d;
    logic    mode_q, mode_d;
    logic    cmd_state;
    logic    id_match;
    logic    id_clear;
    req_t    req;

    octsw_req_build #(.ADDR_BYTES(ADDR_BYTES), .ID_LEN(ID_LEN)) u_build (
        .step        (state_q),
        .target_octal(target_q),
        .cur_octal   (mode_q),
        .req         (req)
    );

    assign id_clear = (state_q == ST_READ_ID) && req_valid && req_ready;

    octsw_id_check #(.ID_LEN(ID_LEN), .EXP_ID(EXP_ID)) u_idchk (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (id_clear),
        .byte_valid(rd_valid && issued_q && state_q == ST_READ_ID),
        .byte_data (rd_data),
        .match     (id_match)
    );

    assign cmd_state = (state_q == ST_EN_DUMMY) || (state_q == ST_EN_MODE) ||
                       (state_q == ST_DIS_MODE) || (state_q == ST_READ_ID);

    // next-state logic
    always_comb begin
        state_d  = state_q;
        issued_d = issued_q;
        target_d = target_q;
        res_d    = res_q;
        mode_d   = mode_q;
        unique case (state_q)
            ST_IDLE: begin
                issued_d = 1'b0;
                if (start_enable ^ start_disable) begin
                    target_d = start_enable;
                    state_d  = start_enable ? ST_EN_DUMMY : ST_DIS_MODE;
                end
            end
            ST_EN_DUMMY, ST_EN_MODE, ST_DIS_MODE, ST_READ_ID: begin
                if (!issued_q && req_ready) issued_d = 1'b1;
                if (issued_q && rsp_valid) begin
                    issued_d = 1'b0;
                    if (rsp_err) begin
                        res_d   = RES_XFER_ERR;
                        state_d = ST_FINISH;
                    end else begin
                        unique case (state_q)
                            ST_EN_DUMMY: state_d = ST_EN_MODE;
                            ST_EN_MODE:  state_d = ST_READ_ID;
                            ST_DIS_MODE: state_d = ST_READ_ID;
                            default: begin
                                state_d = ST_FINISH;
                                if (id_match) begin
                                    res_d  = RES_OK;
                                    mode_d = target_q;
                                end else begin
                                    res_d = RES_ID_BAD;
                                end
                            end
                        endcase
                    end
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            issued_q <= 1'b0;
            target_q <= 1'b0;
            res_q    <= RES_OK;
            mode_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            issued_q <= issued_d;
            target_q <= target_d;
            res_q    <= res_d;
            mode_q   <= mode_d;
        end
    end

    // outputs
    always_comb begin
        busy           = (state_q != ST_IDLE);
        done           = (state_q == ST_FINISH);
        result         = res_q;
        octal_mode     = mode_q;
        req_valid      = cmd_state && !issued_q;
        req_opcode     = req.opcode;
        req_addr_bytes = req.addr_bytes;
        req_addr       = req.addr;
        req_dummy      = req.dummy;
        req_data_len   = req.data_len;
        req_is_read    = req.is_read;
        req_wdata      = req.wdata;
        req_proto      = req.proto;
    end

    p_accept_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_enable ^ start_disable));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'd3));

    p_err_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !req_valid && rsp_valid && rsp_err) |=>
        (done && result == RES_XFER_ERR && !req_valid));

    p_mode_on_ok_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (octal_mode != $past(octal_mode)) |-> (done && result == RES_OK));

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
        (req_valid && $stable(req_opcode) && $stable(req_addr) &&
         $stable(req_proto) && $stable(req_data_len)));
endmodule

// File: tb/tb_octal_mode_switcher.sv
`timescale 1ns/1ps
module tb_octal_mode_switcher;
    localparam int          ADDR_BYTES = 3;
    localparam int          ID_LEN     = 3;
    localparam logic [47:0] EXP_ID     = 48'h0000_00A7_19C2;
    localparam int          NVEC       = 14;

    // {dir(1)=enable, err_at(2), bad_pos(3), nsend(3)}
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b1, 2'd0, 3'd0, 3'd3},   // enable ok
        {1'b0, 2'd0, 3'd0, 3'd3},   // disable ok
        {1'b1, 2'd1, 3'd0, 3'd3},   // enable, err on 1st
        {1'b1, 2'd2, 3'd0, 3'd3},   // enable, err on 2nd
        {1'b1, 2'd3, 3'd0, 3'd3},   // enable, err on ID read
        {1'b1, 2'd0, 3'd2, 3'd3},   // enable, byte 1 wrong
        {1'b1, 2'd0, 3'd0, 3'd5},   // enable, extra bytes
        {1'b1, 2'd0, 3'd0, 3'd3},   // enable from octal
        {1'b0, 2'd1, 3'd0, 3'd3},   // disable, err on 1st
        {1'b0, 2'd0, 3'd3, 3'd3},   // disable, last byte wrong
        {1'b0, 2'd0, 3'd0, 3'd2},   // disable, short ID
        {1'b0, 2'd2, 3'd0, 3'd3},   // disable, err on ID read
        {1'b0, 2'd0, 3'd0, 3'd3},   // disable ok
        {1'b1, 2'd0, 3'd1, 3'd3}    // enable, byte 0 wrong
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_enable = 1'b0;
    logic        start_disable = 1'b0;
    logic        busy, done, octal_mode, req_valid;
    logic [1:0]  result;
    logic        req_ready = 1'b0;
    logic [7:0]  req_opcode;
    logic [2:0]  req_addr_bytes;
    logic [31:0] req_addr;
    logic [4:0]  req_dummy;
    logic [2:0]  req_data_len;
    logic        req_is_read;
    logic [15:0] req_wdata;
    logic [1:0]  req_proto;
    logic        rsp_valid = 1'b0;
    logic        rsp_err = 1'b0;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_data = 8'd0;

    int checks = 0;
    int fails  = 0;
    logic model_mode = 1'b0;

    always #5 clk = ~clk;

    octal_mode_switcher #(.ADDR_BYTES(ADDR_BYTES), .ID_LEN(ID_LEN), .EXP_ID(EXP_ID)) dut (
        .clk(clk), .rst_n(rst_n),
        .start_enable(start_enable), .start_disable(start_disable),
        .busy(busy), .done(done), .result(result), .octal_mode(octal_mode),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_addr_bytes(req_addr_bytes), .req_addr(req_addr),
        .req_dummy(req_dummy), .req_data_len(req_data_len), .req_is_read(req_is_read),
        .req_wdata(req_wdata), .req_proto(req_proto),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_req(input bit dir, input int t, input logic mode_before);
        string tg;
        if (dir && t == 1) begin
            tg = "R4";
            chk(tg, "opcode", 32'(req_opcode), 32'h81);
            chk(tg, "abytes", 32'(req_addr_bytes), 32'(ADDR_BYTES));
            chk(tg, "addr", req_addr, 32'h01);
            chk(tg, "dummy", 32'(req_dummy), 0);
            chk(tg, "len", 32'(req_data_len), 1);
            chk(tg, "read", 32'(req_is_read), 0);
            chk(tg, "wdata", 32'(req_wdata[7:0]), 32'd20);
            chk(tg, "proto", 32'(req_proto), 32'(mode_before));
        end else if (dir && t == 2) begin
            tg = "R5";
            chk(tg, "opcode", 32'(req_opcode), 32'h81);
            chk(tg, "abytes", 32'(req_addr_bytes), 32'(ADDR_BYTES));
            chk(tg, "addr", req_addr, 32'h00);
            chk(tg, "len", 32'(req_data_len), 1);
            chk(tg, "read", 32'(req_is_read), 0);
            chk(tg, "wdata", 32'(req_wdata[7:0]), 32'hE7);
            chk(tg, "proto", 32'(req_proto), 32'(mode_before));
        end else if (!dir && t == 1) begin
            tg = "R7";
            chk(tg, "opcode", 32'(req_opcode), 32'h81);
            chk(tg, "abytes", 32'(req_addr_bytes), 32'(ADDR_BYTES));
            chk(tg, "addr", req_addr, 32'h00);
            chk(tg, "dummy", 32'(req_dummy), 0);
            chk(tg, "len", 32'(req_data_len), 2);
            chk(tg, "read", 32'(req_is_read), 0);
            chk(tg, "wdata", 32'(req_wdata), 32'h1FFF);
            chk(tg, "proto", 32'(req_proto), 1);
        end else begin
            tg = dir ? "R6" : "R8";
            chk(tg, "opcode", 32'(req_opcode), 32'h9F);
            chk(tg, "abytes", 32'(req_addr_bytes), 0);
            chk(tg, "dummy", 32'(req_dummy), dir ? 8 : 0);
            chk(tg, "len", 32'(req_data_len), 32'(ID_LEN));
            chk(tg, "read", 32'(req_is_read), 1);
            chk(tg, "proto", 32'(req_proto), dir ? 1 : 0);
        end
    endtask

    task automatic run_vec(input bit dir, input int err_at, input int bad_pos, input int nsend);
        int  ntx;
        int  exp_res;
        logic exp_mode;
        logic mode_before;
        bit  stop;
        logic [7:0] op0;
        ntx = dir ? 3 : 2;
        mode_before = model_mode;
        if (err_at != 0 && err_at <= ntx) exp_res = 1;
        else if ((bad_pos != 0 && bad_pos <= ID_LEN && bad_pos <= nsend) || nsend < ID_LEN) exp_res = 2;
        else exp_res = 0;
        exp_mode = (exp_res == 0) ? dir : model_mode;
        stop = 1'b0;

        @(negedge clk);
        start_enable  = dir;
        start_disable = !dir;
        @(negedge clk);
        start_enable  = 1'b0;
        start_disable = 1'b0;
        chk("R3", "busy after accept", 32'(busy), 1);

        for (int t = 1; t <= ntx && !stop; t++) begin
            for (int w = 0; w < 50; w++) begin
                if (req_valid || done) break;
                @(negedge clk);
            end
            chk("R2", "request present", 32'(req_valid), 1);
            if (!req_valid) begin
                stop = 1'b1;
            end else begin
                check_req(dir, t, mode_before);
                op0 = req_opcode;
                repeat (2) @(negedge clk);
                chk("R12", "held valid", 32'(req_valid), 1);
                chk("R12", "held opcode", 32'(req_opcode), 32'(op0));
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
                if (t == 1) begin
                    // start of the other direction while busy: must be ignored (R2)
                    start_enable  = !dir;
                    start_disable = dir;
                    @(negedge clk);
                    start_enable  = 1'b0;
                    start_disable = 1'b0;
                end else begin
                    @(negedge clk);
                end
                if (t == ntx) begin
                    for (int i = 0; i < nsend; i++) begin
                        rd_valid = 1'b1;
                        if (i < ID_LEN)
                            rd_data = EXP_ID[8*i +: 8] ^ ((i == bad_pos - 1) ? 8'hFF : 8'h00);
                        else
                            rd_data = 8'h5A + 8'(i);
                        @(negedge clk);
                    end
                    rd_valid = 1'b0;
                end
                rsp_valid = 1'b1;
                rsp_err   = (t == err_at);
                @(negedge clk);
                rsp_valid = 1'b0;
                rsp_err   = 1'b0;
                if (t == err_at) stop = 1'b1;
            end
        end

        chk("R3", "done pulse", 32'(done), 1);
        chk(exp_res == 1 ? "R10" : (exp_res == 2 ? "R9" : "R3"), "result", 32'(result), 32'(exp_res));
        chk("R11", "mode at done", 32'(octal_mode), 32'(exp_mode));
        chk("R10", "no request at done", 32'(req_valid), 0);
        @(negedge clk);
        chk("R3", "done dropped", 32'(done), 0);
        chk("R3", "busy dropped", 32'(busy), 0);
        chk("R11", "mode kept", 32'(octal_mode), 32'(exp_mode));
        model_mode = exp_mode;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "req_valid", 32'(req_valid), 0);
        chk("R1", "octal_mode", 32'(octal_mode), 0);

        // both starts together: ignored (R2)
        start_enable  = 1'b1;
        start_disable = 1'b1;
        @(negedge clk);
        start_enable  = 1'b0;
        start_disable = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R2", "both starts busy", 32'(busy), 0);
            chk("R2", "both starts req", 32'(req_valid), 0);
            @(negedge clk);
        end

        for (int v = 0; v < NVEC; v++) begin
            run_vec(VEC[v][8], int'(VEC[v][7:6]), int'(VEC[v][5:3]), int'(VEC[v][2:0]));
        end

        repeat (2) @(negedge clk);
        chk("R1", "idle at end", 32'(busy), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule